// File: doc/BRIEF.md
# Coprocessor Instruction Stream Tracker

This block sits on the coprocessor side of a shared host bus and follows the host's instruction stream without being told what the host executes. Status lines on every observed bus cycle say whether it is an instruction fetch, a data read or a host write. From these the block spots escape opcodes (code bytes 0xD8 to 0xDF) and takes the byte that follows as the operand-mode byte. For a memory-form escape the host performs one throw-away data read; the block learns the operand address from that read instead of decoding the addressing mode itself.

A load keeps the word returned by that read and fetches the rest of the operand itself as bus master. A store ignores the returned word. After a modelled execution latency it writes its own result words back to the captured address. Register-form escapes carry a stack index in the low three bits of the mode byte and cause no bus traffic. From the moment an escape is seen until the operation ends, the busy output is high. Any escape that appears during that time is dropped without trace.

Two valid/ready interfaces carry data. The decoded operation leaves on `op_*`: it is held, unchanged, while `op_ready` is low, and the latency count starts only once it is taken. Operand traffic uses the bus-master port `m_*`. A request is held with a fixed address, direction and write data until `m_ready` is sampled high. Read data on `m_rdata` is taken in that same cycle.

Top module: `cst_tracker`

## Requirements
- R1: In idle, a code fetch whose byte has bits [7:3] = 5'b11011 is an escape, and the next code fetch is its mode byte. The reported code is {escape[2:0], mode[5:3]}. Other code bytes, host writes and data reads in idle start nothing.
- R2: A mode byte with bits [7:6] = 2'b11 is register form. The operation reports op_mem = 0, op_rm = mode[2:0], op_addr = 0 and op_sum = 0, and the block makes no bus request.
- R3: For a memory form, code fetches between the mode byte and the first host data read (status not code, not write) are skipped. That read's address becomes op_addr, and op_mem = 1.
- R4: A memory form with mode[4] = 0 is a load of N words, where N is the entry for escape[2:0] of WORDS_BY_GRP (default 1, 2, 4, 5, 1, 2, 4, 5 for groups 0 to 7). Word 0 is the host read's data. Words 1 to N-1 are read at op_addr + 2*i, wrapping at AW bits, and op_sum is the XOR of all N words.
- R5: A memory form with mode[4] = 1 is a store, reported with op_store = 1 and op_sum = 0 whatever the host read returned. After the latency it writes N words at op_addr + 2*i. The data of word i is {2'b10, code[5:0], i[7:0]}.
- R6: Take L as the entry for escape[2:0] of LAT_BY_GRP (default 3 + group). After the operation is taken, busy stays high for exactly L + 1 cycles on loads and register forms. On a store with m_ready held high it stays high for L + N + 1 cycles.
- R7: An escape, mode byte and data read seen while busy is high produce no operation and no bus request.
- R8: op_valid, once raised, holds with stable fields until op_ready is high.
- R9: m_valid, once raised, holds with stable m_addr, m_write and m_wdata until m_ready is high. A request that is taken is followed either by the end of the burst or by the next word at the address plus 2.
- R10: During and after reset, busy, op_valid and m_valid are low.
- R11: op_valid and m_valid are high only while busy is high, and busy falls only in a cycle that follows one without any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_valid | input | 1 | A host bus cycle is observed this clock |
| snoop_code | input | 1 | Observed cycle is an instruction fetch |
| snoop_write | input | 1 | Observed cycle is a host write |
| snoop_addr | input | AW | Address of the observed cycle |
| snoop_data | input | 16 | Data of the observed cycle (code byte in [7:0]) |
| busy | output | 1 | Operation in progress |
| op_valid | output | 1 | Decoded operation available |
| op_ready | input | 1 | Consumer takes the decoded operation |
| op_code | output | 6 | Six-bit coprocessor operation code |
| op_mem | output | 1 | Memory form |
| op_store | output | 1 | Memory form that stores results |
| op_rm | output | 3 | Stack register index or addressing field |
| op_addr | output | AW | Captured operand address |
| op_sum | output | 16 | XOR of load operand words |
| m_valid | output | 1 | Bus-master request |
| m_ready | input | 1 | Bus accepts the request this clock |
| m_write | output | 1 | Request is a write |
| m_addr | output | AW | Request address |
| m_wdata | output | 16 | Write data |
| m_rdata | input | 16 | Read data, valid in the accepting clock |

## Verification
The bench aims at escapes arriving while busy, at displacement bytes placed between the mode byte and the host read, and at single-word loads that need no bus reads. A tracker that is not gated by busy would issue a phantom second operation. One that latched the first data cycle of any kind, or the wrong one, would report a displacement-related address. An operand sequence that goes one word too far or too few would show up in the read count and in the XOR. Stores get dummy data that is nonzero, so a design that mixed it into the result would be caught. Operand bursts also cross the top of the address space, where a carry mistake moves the later words. Stalls on both handshakes check that latency is counted from acceptance and that stalled requests do not skip or repeat words.

// File: rtl/cst_pkg.sv
package cst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODRM,
    ST_DUMMY,
    ST_LOAD,
    ST_ISSUE,
    ST_EXEC,
    ST_STORE,
    ST_RELEASE
  } trk_state_e;

  typedef struct packed {
    logic [5:0] code;
    logic       mem;
    logic       store;
    logic [2:0] rm;
  } esc_op_t;

  function automatic logic is_escape(input logic [7:0] b);
    return b[7:3] == 5'b11011;
  endfunction

endpackage

// File: rtl/cst_esc_decode.sv
module cst_esc_decode
  import cst_pkg::*;
#(
  parameter int CW = 3,
  parameter int LW = 8,
  parameter logic [8*CW-1:0] WORDS_BY_GRP = {3'd5, 3'd4, 3'd2, 3'd1, 3'd5, 3'd4, 3'd2, 3'd1},
  parameter logic [8*LW-1:0] LAT_BY_GRP   = {8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3}
) (
  input  logic [2:0]    grp,
  input  logic [7:0]    modrm,
  output esc_op_t       op,
  output logic [CW-1:0] words,
  output logic [LW-1:0] lat
);

  logic [CW-1:0] raw_words;
  logic [LW-1:0] raw_lat;

  always_comb begin
    raw_words = WORDS_BY_GRP[int'(grp)*CW +: CW];
    raw_lat   = LAT_BY_GRP[int'(grp)*LW +: LW];
    // a zero entry would stall the sequencer or the timer: clamp to one
    words     = (raw_words == '0) ? CW'(1) : raw_words;
    lat       = (raw_lat == '0) ? LW'(1) : raw_lat;
    op.code   = {grp, modrm[5:3]};
    op.mem    = (modrm[7:6] != 2'b11);
    op.store  = (modrm[7:6] != 2'b11) && modrm[4];
    op.rm     = modrm[2:0];
  end

endmodule

// File: rtl/cst_lat_timer.sv
module cst_lat_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] load,
  output logic          done
);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= load;
    else if (cnt != '0)    cnt <= cnt - LW'(1);
  end

  // high in the last of the 'load' cycles that follow start
  assign done = (cnt == LW'(1));

endmodule

// File: rtl/cst_word_seq.sv
module cst_word_seq #(
  parameter int AW = 20,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] first_idx,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] idx
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      idx  <= '0;
    end else if (init) begin
      addr <= base + AW'({first_idx, 1'b0});
      idx  <= first_idx;
    end else if (step) begin
      addr <= addr + AW'(2);
      idx  <= idx + CW'(1);
    end
  end

endmodule

// File: rtl/cst_tracker.sv
module cst_tracker
  import cst_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 3,
  parameter int LW = 8,
  parameter logic [8*CW-1:0] WORDS_BY_GRP = {3'd5, 3'd4, 3'd2, 3'd1, 3'd5, 3'd4, 3'd2, 3'd1},
  parameter logic [8*LW-1:0] LAT_BY_GRP   = {8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snoop_valid,
  input  logic          snoop_code,
  input  logic          snoop_write,
  input  logic [AW-1:0] snoop_addr,
  input  logic [15:0]   snoop_data,
  output logic          busy,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [5:0]    op_code,
  output logic          op_mem,
  output logic          op_store,
  output logic [2:0]    op_rm,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_sum,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [15:0]   m_wdata,
  input  logic [15:0]   m_rdata
);

  trk_state_e    st, st_n;
  logic [2:0]    grp_q;
  esc_op_t       op_q;
  logic [CW-1:0] words_q;
  logic [LW-1:0] lat_q;
  logic [AW-1:0] base_q;
  logic [15:0]   sum_q;

  esc_op_t       dec_op;
  logic [CW-1:0] dec_words;
  logic [LW-1:0] dec_lat;

  logic          seq_init, seq_step;
  logic [AW-1:0] seq_base, seq_addr;
  logic [CW-1:0] seq_first, seq_idx;
  logic          t_done;

  logic evt_code, evt_dread, hs_m, hs_op, last_word;

  assign evt_code  = snoop_valid && snoop_code;
  assign evt_dread = snoop_valid && !snoop_code && !snoop_write;
  assign hs_m      = m_valid && m_ready;
  assign hs_op     = op_valid && op_ready;
  assign last_word = (seq_idx == words_q - CW'(1));

  cst_esc_decode #(
    .CW(CW), .LW(LW), .WORDS_BY_GRP(WORDS_BY_GRP), .LAT_BY_GRP(LAT_BY_GRP)
  ) u_dec (
    .grp   (grp_q),
    .modrm (snoop_data[7:0]),
    .op    (dec_op),
    .words (dec_words),
    .lat   (dec_lat)
  );

  cst_word_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (seq_init),
    .base      (seq_base),
    .first_idx (seq_first),
    .step      (seq_step),
    .addr      (seq_addr),
    .idx       (seq_idx)
  );

  cst_lat_timer #(.LW(LW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (hs_op),
    .load  (lat_q),
    .done  (t_done)
  );

  always_comb begin
    st_n      = st;
    seq_init  = 1'b0;
    seq_step  = 1'b0;
    seq_base  = snoop_addr;
    seq_first = '0;
    case (st)
      ST_IDLE:
        if (evt_code && is_escape(snoop_data[7:0])) st_n = ST_MODRM;
      ST_MODRM:
        if (evt_code) st_n = dec_op.mem ? ST_DUMMY : ST_ISSUE;
      ST_DUMMY:
        if (evt_dread) begin
          if (!op_q.store && (words_q > CW'(1))) begin
            seq_init  = 1'b1;
            seq_first = CW'(1);
            st_n      = ST_LOAD;
          end else begin
            st_n = ST_ISSUE;
          end
        end
      ST_LOAD:
        if (hs_m) begin
          seq_step = 1'b1;
          if (last_word) st_n = ST_ISSUE;
        end
      ST_ISSUE:
        if (hs_op) st_n = ST_EXEC;
      ST_EXEC:
        if (t_done) begin
          if (op_q.store) begin
            seq_init = 1'b1;
            seq_base = base_q;
            st_n     = ST_STORE;
          end else begin
            st_n = ST_RELEASE;
          end
        end
      ST_STORE:
        if (hs_m) begin
          seq_step = 1'b1;
          if (last_word) st_n = ST_RELEASE;
        end
      ST_RELEASE:
        st_n = ST_IDLE;
      default:
        st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      grp_q   <= '0;
      op_q    <= '0;
      words_q <= CW'(1);
      lat_q   <= LW'(1);
      base_q  <= '0;
      sum_q   <= '0;
    end else begin
      st <= st_n;
      case (st)
        ST_IDLE:
          if (evt_code && is_escape(snoop_data[7:0])) grp_q <= snoop_data[2:0];
        ST_MODRM:
          if (evt_code) begin
            op_q    <= dec_op;
            words_q <= dec_words;
            lat_q   <= dec_lat;
            base_q  <= '0;
            sum_q   <= '0;
          end
        ST_DUMMY:
          if (evt_dread) begin
            base_q <= snoop_addr;
            sum_q  <= op_q.store ? 16'h0000 : snoop_data;
          end
        ST_LOAD:
          if (hs_m) sum_q <= sum_q ^ m_rdata;
        default: ;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign op_valid = (st == ST_ISSUE);
  assign op_code  = op_q.code;
  assign op_mem   = op_q.mem;
  assign op_store = op_q.store;
  assign op_rm    = op_q.rm;
  assign op_addr  = base_q;
  assign op_sum   = sum_q;
  assign m_valid  = (st == ST_LOAD) || (st == ST_STORE);
  assign m_write  = (st == ST_STORE);
  assign m_addr   = seq_addr;
  assign m_wdata  = {2'b10, op_q.code, 8'(seq_idx)};

endmodule

// File: rtl/cst_tracker_chk.sv
module cst_tracker_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          op_valid,
  input logic          op_ready,
  input logic [5:0]    op_code,
  input logic [AW-1:0] op_addr,
  input logic [15:0]   op_sum,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_write,
  input logic [AW-1:0] m_addr,
  input logic [15:0]   m_wdata
);

  assert_op_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_code) && $stable(op_addr) && $stable(op_sum)));

  assert_master_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> (!m_valid || (m_addr == $past(m_addr) + AW'(2))));

  // after the operation is taken there is no operand read: only latency, then stores or release
  assert_no_read_after_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (busy && !m_valid && !op_valid));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!m_valid && !op_valid));

  assert_release_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!$past(m_valid) && !$past(op_valid)));

endmodule

bind cst_tracker cst_tracker_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_code  (op_code),
  .op_addr  (op_addr),
  .op_sum   (op_sum),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_write  (m_write),
  .m_addr   (m_addr),
  .m_wdata  (m_wdata)
);

// File: tb/tb_cst_tracker.sv
`timescale 1ns/1ps
module tb_cst_tracker;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          snoop_valid = 1'b0, snoop_code = 1'b0, snoop_write = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic [15:0]   snoop_data = '0;
  logic          busy, op_valid, op_mem, op_store, m_valid, m_write;
  logic          op_ready = 1'b1, m_ready = 1'b1;
  logic [5:0]    op_code;
  logic [2:0]    op_rm;
  logic [AW-1:0] op_addr, m_addr;
  logic [15:0]   op_sum, m_wdata, m_rdata;

  int total = 0, fails = 0;
  int ready_mode = 0, cyc = 0;
  int n_ops = 0, nrd = 0, nwr = 0, busy_after = 0;
  logic op_seen = 1'b0;
  logic [AW-1:0] wr_addr [64];
  logic [15:0]   wr_data [64];
  logic [AW-1:0] rd_addr [64];
  logic [5:0]    c_code;
  logic          c_mem, c_store;
  logic [2:0]    c_rm;
  logic [AW-1:0] c_addr;
  logic [15:0]   c_sum;

  always #5 clk = ~clk;

  cst_tracker dut (
    .clk(clk), .rst_n(rst_n), .snoop_valid(snoop_valid), .snoop_code(snoop_code),
    .snoop_write(snoop_write), .snoop_addr(snoop_addr), .snoop_data(snoop_data),
    .busy(busy), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_mem(op_mem), .op_store(op_store), .op_rm(op_rm), .op_addr(op_addr),
    .op_sum(op_sum), .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  function automatic logic [15:0] mem_model(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign m_rdata = mem_model(m_addr);

  function automatic int exp_words(input int g);
    case (g % 4)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_lat(input int g);
    return 3 + g;
  endfunction

  // handshake readiness changes shortly after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    m_ready  = (ready_mode[0] == 1'b0) ? 1'b1 : ((cyc % 3) != 0);
    op_ready = (ready_mode[1] == 1'b0) ? 1'b1 : ((cyc % 4) == 3);
  end

  // monitor samples at the falling edge
  always @(negedge clk) begin
    if (op_seen && busy) busy_after++;
    if (m_valid && m_ready) begin
      if (m_write) begin
        wr_addr[nwr % 64] = m_addr;
        wr_data[nwr % 64] = m_wdata;
        nwr++;
      end else begin
        rd_addr[nrd % 64] = m_addr;
        nrd++;
      end
    end
    if (op_valid && op_ready) begin
      c_code = op_code; c_mem = op_mem; c_store = op_store;
      c_rm = op_rm; c_addr = op_addr; c_sum = op_sum;
      n_ops++;
      op_seen = 1'b1;
      busy_after = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snoop(input logic code, input logic wr, input logic [AW-1:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    snoop_valid = 1'b1; snoop_code = code; snoop_write = wr;
    snoop_addr = a; snoop_data = d;
    @(posedge clk); #2;
    snoop_valid = 1'b0; snoop_code = 1'b0; snoop_write = 1'b0;
  endtask

  task automatic wait_ops(input int target);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (n_ops >= target) break;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // {escape, mode byte, host read address, host read data, handshake mode}
  localparam logic [53:0] VECS [9] = '{
    {8'hD9, 8'hC3, 20'h00000, 16'h0000, 2'd0},
    {8'hDA, 8'h07, 20'h01000, 16'h1111, 2'd0},
    {8'hDB, 8'h47, 20'h01100, 16'h2222, 2'd1},
    {8'hDD, 8'h17, 20'h02040, 16'hBEEF, 2'd0},
    {8'hDF, 8'h9E, 20'h03000, 16'h7777, 2'd3},
    {8'hD8, 8'h05, 20'h04000, 16'h0AAA, 2'd0},
    {8'hDC, 8'h25, 20'h05000, 16'h1234, 2'd2},
    {8'hDE, 8'hF8, 20'h00000, 16'h0000, 2'd2},
    {8'hDA, 8'h00, 20'hFFFFC, 16'h4321, 2'd0}
  };

  task automatic run_vec(input logic [53:0] v);
    logic [7:0]    esc, mdb;
    logic [AW-1:0] a, ea;
    logic [15:0]   d, s;
    logic          mem, st;
    int g, nw, lat, ops0, rd0, wr0;
    esc = v[53:46]; mdb = v[45:38]; a = v[37:18]; d = v[17:2];
    ready_mode = int'(v[1:0]);
    g = int'(esc[2:0]); nw = exp_words(g); lat = exp_lat(g);
    mem = (mdb[7:6] != 2'b11); st = mem && mdb[4];
    ops0 = n_ops; rd0 = nrd; wr0 = nwr;
    snoop(1'b1, 1'b0, '0, {8'h00, esc});
    snoop(1'b1, 1'b0, '0, {8'h00, mdb});
    if (mem) begin
      snoop(1'b1, 1'b0, '0, 16'h0034);    // displacement byte, skipped (R3)
      snoop(1'b0, 1'b0, a, d);
    end
    wait_ops(ops0 + 1);
    wait_idle();
    chk("R1 op count", 32'(n_ops - ops0), 32'd1);
    chk("R1 op code", 32'(c_code), 32'({esc[2:0], mdb[5:3]}));
    chk("R2 op mem", 32'(c_mem), 32'(mem));
    chk("R2 op rm", 32'(c_rm), 32'(mdb[2:0]));
    chk("R3 op addr", 32'(c_addr), mem ? 32'(a) : 32'd0);
    chk("R5 op store", 32'(c_store), 32'(st));
    if (mem && !st) begin
      s = d;
      for (int i = 1; i < nw; i++) begin
        ea = a + AW'(2 * i);
        s = s ^ mem_model(ea);
        chk("R4 read addr", 32'(rd_addr[(rd0 + i - 1) % 64]), 32'(ea));
      end
      chk("R4 op sum", 32'(c_sum), 32'(s));
      chk("R4 read count", 32'(nrd - rd0), 32'(nw - 1));
    end else begin
      chk("R2 R5 op sum", 32'(c_sum), 32'd0);
      chk("R2 read count", 32'(nrd - rd0), 32'd0);
    end
    if (st) begin
      chk("R5 write count", 32'(nwr - wr0), 32'(nw));
      for (int i = 0; i < nw; i++) begin
        chk("R5 write addr", 32'(wr_addr[(wr0 + i) % 64]), 32'(a + AW'(2 * i)));
        chk("R5 write data", 32'(wr_data[(wr0 + i) % 64]),
            32'({2'b10, esc[2:0], mdb[5:3], 8'(i)}));
      end
    end else begin
      chk("R2 R4 write count", 32'(nwr - wr0), 32'd0);
    end
    if (!st) chk("R6 busy length", 32'(busy_after), 32'(lat + 1));
    else if (ready_mode[0] == 1'b0) chk("R6 busy length store", 32'(busy_after), 32'(lat + nw + 1));
  endtask

  initial begin
    int ops0, rd0;
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", 32'(busy), 32'd0);
    chk("R10 op_valid in reset", 32'(op_valid), 32'd0);
    chk("R10 m_valid in reset", 32'(m_valid), 32'd0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", 32'(busy), 32'd0);

    foreach (VECS[k]) run_vec(VECS[k]);

    // non-escape code bytes and stray data reads start nothing (R1)
    ready_mode = 0;
    ops0 = n_ops; rd0 = nrd;
    snoop(1'b1, 1'b0, '0, 16'h0090);
    snoop(1'b1, 1'b0, '0, 16'h00C3);
    snoop(1'b0, 1'b0, 20'h06000, 16'h5555);
    snoop(1'b0, 1'b1, 20'h06002, 16'h6666);
    repeat (20) @(negedge clk);
    chk("R1 non-escape busy", 32'(busy), 32'd0);
    chk("R1 non-escape op count", 32'(n_ops - ops0), 32'd0);
    chk("R1 non-escape reads", 32'(nrd - rd0), 32'd0);

    // escape arriving while busy is dropped (R7)
    ops0 = n_ops; rd0 = nrd;
    snoop(1'b1, 1'b0, '0, 16'h00DF);
    snoop(1'b1, 1'b0, '0, 16'h00C0);
    wait_ops(ops0 + 1);
    snoop(1'b1, 1'b0, '0, 16'h00DA);
    snoop(1'b1, 1'b0, '0, 16'h0007);
    snoop(1'b0, 1'b0, 20'h07000, 16'h9999);
    wait_idle();
    repeat (30) @(negedge clk);
    chk("R7 dropped op count", 32'(n_ops - ops0), 32'd1);
    chk("R7 dropped reads", 32'(nrd - rd0), 32'd0);
    chk("R7 idle after drop", 32'(busy), 32'd0);

    summary();
    $finish;
  end

  initial begin
    #1500000;
    total++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule